// File: doc/BRIEF.md
# Data Translation and Fault Status Unit

This block sits beside a data translation buffer and turns each load or store virtual address into a physical address, or into one of four fault kinds. The buffer lookup is done outside the block. Its result comes in as a hit bit, a page frame number, per-mode read and write enable vectors, and two trap-on-access bits. The block decides the effective privilege mode and applies a fixed order of checks: address validity first, then the superpage window, then the buffer miss, then permissions.

When a fault is reported, three status registers are loaded: the faulting address, a packed status word, and a formatted address that points into the page table. The registers then lock, so a later fault cannot overwrite the first fault's record. The lock clears when software strobes a read of the address register.

Six counters record read and write hits, misses and violations. From them the block derives per-direction access counts and the combined totals. A response is registered one cycle after its request.

Top module: `dxlate_unit`

## Requirements
- R1: Modes are encoded kernel=0, executive=1, supervisor=2, user=3. The effective mode is `cur_mode`, except when `priv_pc` is high. In that case it is kernel, or `alt_mode` when `req_altmode` is also high. `req_altmode` has no effect while `priv_pc` is low.
- R2: Fault codes on `rsp_fault` are 0 none, 1 protection, 2 trap, 3 miss, 4 page-table miss. The checks run in this order: address validity, superpage, buffer hit, permission. An invalid address (`va_ok` low) gives code 2 with the bad-address and violation flags set, plus the write flag on stores.
- R3: When `spage_on` is high and VA[42:41] equals 2, the buffer result is ignored. In that case the physical address is VA[40:0] if `cur_mode` is kernel. Otherwise the result is code 1 with the violation flag. The check uses the current mode, not the effective mode.
- R4: A buffer miss sets the miss flag. It gives code 4 when `req_ptefetch` is high, and code 3 otherwise.
- R5: On a store hit, if the effective mode's bit of `tlb_wr_en` is clear, the result is code 2 with the write and violation flags, plus the write-trap flag if `tlb_wr_trap` is set. If the bit is set but `tlb_wr_trap` is set, the result is code 2 with the write and write-trap flags.
- R6: On a load hit, if the effective mode's bit of `tlb_rd_en` is clear, the result is code 1 with the violation flag, plus the read-trap flag if `tlb_rd_trap` is set. If the bit is set but `tlb_rd_trap` is set, the result is code 2 with only the read-trap flag.
- R7: An access that passes every check gives code 0 and the physical address {`tlb_pfn`, VA[12:0]}. Both appear one cycle after the request.
- R8: A fault that is recorded loads three registers. `fst_va` gets the VA. `fst_word` gets {opcode[5:0] at 16:11, destination register[4:0] at 10:6, flags at 5:0}, with flag bits write=0, violation=1, read-trap=2, write-trap=3, bad address=4, miss=5. `fst_fva` gets `pt_base` OR (VA[42:13] << 3).
- R9: A fault is recorded only while `fst_locked` is low, and recording it sets the lock. `va_rd` clears the lock one cycle later. A fault arriving in the same cycle as `va_rd` while locked is not recorded.
- R10: The counters count read and write hits, misses and violations separately. Violations are codes 1 and 2; misses are codes 3 and 4. Access counts and totals are sums of these counters. Cycles without a request change no counter.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 43 | Virtual address |
| req_write | input | 1 | Store when high, load when low |
| req_altmode | input | 1 | Use the alternate mode in privileged code |
| req_ptefetch | input | 1 | Access is a page-table-entry fetch |
| req_opcode | input | 6 | Opcode recorded into the status word |
| req_rdst | input | 5 | Destination register recorded into the status word |
| cur_mode | input | 2 | Current data mode |
| alt_mode | input | 2 | Alternate mode value |
| priv_pc | input | 1 | Program counter is in privileged code |
| spage_on | input | 1 | Superpage window enable |
| va_ok | input | 1 | Address passed the validity check |
| tlb_hit | input | 1 | Buffer lookup hit |
| tlb_pfn | input | 28 | Page frame number from the buffer |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_rd_trap | input | 1 | Trap on read |
| tlb_wr_trap | input | 1 | Trap on write |
| pt_base | input | 64 | Page table base for the formatted address |
| va_rd | input | 1 | Read strobe of the fault address register |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | Fault code |
| rsp_paddr | output | 41 | Physical address |
| fst_va | output | 43 | Recorded fault address |
| fst_word | output | 17 | Packed fault status word |
| fst_fva | output | 64 | Formatted fault address |
| fst_locked | output | 1 | Status registers locked |
| rd_hits | output | 16 | Read hits |
| rd_misses | output | 16 | Read misses |
| rd_viol | output | 16 | Read violations |
| rd_acc | output | 16 | Read accesses |
| wr_hits | output | 16 | Write hits |
| wr_misses | output | 16 | Write misses |
| wr_viol | output | 16 | Write violations |
| wr_acc | output | 16 | Write accesses |
| all_hits | output | 16 | Total hits |
| all_misses | output | 16 | Total misses |
| all_viol | output | 16 | Total violations |
| all_acc | output | 16 | Total accesses |

## Verification
The fault code, the physical address, the status registers, the lock and the counters all change at the first rising edge after a request is sampled. A lock clear is due at the first rising edge after the `va_rd` strobe. The bench changes inputs just after a falling edge and reads results at the next falling edge, so every sample falls exactly one register stage after its stimulus. The lock tests read the status registers after each step of a fault, fault, read, fault-with-read sequence, so both the retained record and the dropped record are observed.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_PROT   = 3'd1,
        FLT_TRAP   = 3'd2,
        FLT_MISS   = 3'd3,
        FLT_PTMISS = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        OUT_HIT  = 2'd0,
        OUT_MISS = 2'd1,
        OUT_VIOL = 2'd2
    } outcome_e;

    // first field is the most significant flag bit
    typedef struct packed {
        logic miss;
        logic bad_va;
        logic wr_trap;
        logic rd_trap;
        logic viol;
        logic wr;
    } mmflags_t;

    localparam int NUM_KIND = 3;
    localparam int NUM_CNT  = 2 * NUM_KIND;
    localparam int SPAGE_TAG = 2;

    function automatic mode_e pick_mode(input logic priv, input logic use_alt,
                                        input mode_e cur, input mode_e alt);
        if (!priv)
            return cur;
        return use_alt ? alt : MODE_KERN;
    endfunction

endpackage

// File: rtl/dxl_check.sv
module dxl_check
    import dxl_pkg::*;
#(
    parameter int VA_W  = 43,
    parameter int PG_W  = 13,
    parameter int PFN_W = 28,
    localparam int PA_W = PFN_W + PG_W
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic             write,
    input  logic             altmode,
    input  logic             ptefetch,
    input  mode_e            cur_mode,
    input  mode_e            alt_mode,
    input  logic             priv_pc,
    input  logic             spage_on,
    input  logic             va_ok,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    input  logic [3:0]       rd_en,
    input  logic [3:0]       wr_en,
    input  logic             rd_trap,
    input  logic             wr_trap,
    output fault_e           fault,
    output mmflags_t         flags,
    output outcome_e         outcome,
    output logic [PA_W-1:0]  paddr
);

    mode_e eff_mode;
    logic  in_spage;

    assign eff_mode = pick_mode(priv_pc, altmode, cur_mode, alt_mode);
    assign in_spage = spage_on && (vaddr[VA_W-1 -: 2] == 2'(SPAGE_TAG));

    always_comb begin
        flags    = '0;
        flags.wr = write;
        fault    = FLT_NONE;
        outcome  = OUT_HIT;
        paddr    = {tlb_pfn, vaddr[PG_W-1:0]};
        if (!va_ok) begin
            flags.bad_va = 1'b1;
            flags.viol   = 1'b1;
            fault        = FLT_TRAP;
            outcome      = OUT_VIOL;
        end else if (in_spage) begin
            paddr = vaddr[PA_W-1:0];
            if (cur_mode != MODE_KERN) begin
                flags.viol = 1'b1;
                fault      = FLT_PROT;
                outcome    = OUT_VIOL;
            end
        end else if (!tlb_hit) begin
            flags.miss = 1'b1;
            fault      = ptefetch ? FLT_PTMISS : FLT_MISS;
            outcome    = OUT_MISS;
        end else if (write) begin
            if (!wr_en[eff_mode]) begin
                flags.viol    = 1'b1;
                flags.wr_trap = wr_trap;
                fault         = FLT_TRAP;
                outcome       = OUT_VIOL;
            end else if (wr_trap) begin
                flags.wr_trap = 1'b1;
                fault         = FLT_TRAP;
                outcome       = OUT_VIOL;
            end
        end else begin
            if (!rd_en[eff_mode]) begin
                flags.viol    = 1'b1;
                flags.rd_trap = rd_trap;
                fault         = FLT_PROT;
                outcome       = OUT_VIOL;
            end else if (rd_trap) begin
                flags.rd_trap = 1'b1;
                fault         = FLT_TRAP;
                outcome       = OUT_VIOL;
            end
        end
    end

endmodule

// File: rtl/dxl_status.sv
module dxl_status
    import dxl_pkg::*;
#(
    parameter int VA_W  = 43,
    parameter int PG_W  = 13,
    parameter int FVA_W = 64,
    localparam int VPN_W = VA_W - PG_W,
    localparam int WORD_W = 6 + 5 + $bits(mmflags_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_ev,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [5:0]        opcode,
    input  logic [4:0]        rdst,
    input  mmflags_t          flags,
    input  logic [FVA_W-1:0]  pt_base,
    input  logic              va_rd,
    output logic [VA_W-1:0]   st_va,
    output logic [WORD_W-1:0] st_word,
    output logic [FVA_W-1:0]  st_fva,
    output logic              locked
);

    logic             capture;
    logic [VPN_W-1:0] vpn;

    assign capture = fault_ev && !locked;
    assign vpn     = vaddr[VA_W-1:PG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_va   <= '0;
            st_word <= '0;
            st_fva  <= '0;
            locked  <= 1'b0;
        end else begin
            if (capture) begin
                st_va   <= vaddr;
                st_word <= {opcode, rdst, flags};
                st_fva  <= pt_base | (FVA_W'(vpn) << 3);
            end
            if (capture)
                locked <= 1'b1;
            else if (va_rd)
                locked <= 1'b0;
        end
    end

endmodule

// File: rtl/dxl_counters.sv
module dxl_counters
    import dxl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic             ev_write,
    input  outcome_e         ev_kind,
    output logic [CNT_W-1:0] cnt [NUM_CNT]
);

    logic [2:0] sel;
    assign sel = ev_write ? 3'(NUM_KIND) + 3'(ev_kind) : 3'(ev_kind);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (ev_valid && sel == 3'(g))
                cnt[g] <= cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit
    import dxl_pkg::*;
#(
    parameter int VA_W  = 43,
    parameter int PG_W  = 13,
    parameter int PFN_W = 28,
    parameter int FVA_W = 64,
    parameter int CNT_W = 16,
    localparam int PA_W = PFN_W + PG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_altmode,
    input  logic             req_ptefetch,
    input  logic [5:0]       req_opcode,
    input  logic [4:0]       req_rdst,
    input  logic [1:0]       cur_mode,
    input  logic [1:0]       alt_mode,
    input  logic             priv_pc,
    input  logic             spage_on,
    input  logic             va_ok,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    input  logic [3:0]       tlb_rd_en,
    input  logic [3:0]       tlb_wr_en,
    input  logic             tlb_rd_trap,
    input  logic             tlb_wr_trap,
    input  logic [FVA_W-1:0] pt_base,
    input  logic             va_rd,
    output logic             rsp_valid,
    output logic [2:0]       rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [VA_W-1:0]  fst_va,
    output logic [16:0]      fst_word,
    output logic [FVA_W-1:0] fst_fva,
    output logic             fst_locked,
    output logic [CNT_W-1:0] rd_hits,
    output logic [CNT_W-1:0] rd_misses,
    output logic [CNT_W-1:0] rd_viol,
    output logic [CNT_W-1:0] rd_acc,
    output logic [CNT_W-1:0] wr_hits,
    output logic [CNT_W-1:0] wr_misses,
    output logic [CNT_W-1:0] wr_viol,
    output logic [CNT_W-1:0] wr_acc,
    output logic [CNT_W-1:0] all_hits,
    output logic [CNT_W-1:0] all_misses,
    output logic [CNT_W-1:0] all_viol,
    output logic [CNT_W-1:0] all_acc
);

    fault_e           c_fault;
    mmflags_t         c_flags;
    outcome_e         c_kind;
    logic [PA_W-1:0]  c_paddr;
    logic [CNT_W-1:0] cnt [NUM_CNT];

    dxl_check #(.VA_W(VA_W), .PG_W(PG_W), .PFN_W(PFN_W)) i_check (
        .vaddr    (req_vaddr),
        .write    (req_write),
        .altmode  (req_altmode),
        .ptefetch (req_ptefetch),
        .cur_mode (mode_e'(cur_mode)),
        .alt_mode (mode_e'(alt_mode)),
        .priv_pc  (priv_pc),
        .spage_on (spage_on),
        .va_ok    (va_ok),
        .tlb_hit  (tlb_hit),
        .tlb_pfn  (tlb_pfn),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .rd_trap  (tlb_rd_trap),
        .wr_trap  (tlb_wr_trap),
        .fault    (c_fault),
        .flags    (c_flags),
        .outcome  (c_kind),
        .paddr    (c_paddr)
    );

    dxl_status #(.VA_W(VA_W), .PG_W(PG_W), .FVA_W(FVA_W)) i_status (
        .clk      (clk),
        .rst      (rst),
        .fault_ev (req_valid && c_fault != FLT_NONE),
        .vaddr    (req_vaddr),
        .opcode   (req_opcode),
        .rdst     (req_rdst),
        .flags    (c_flags),
        .pt_base  (pt_base),
        .va_rd    (va_rd),
        .st_va    (fst_va),
        .st_word  (fst_word),
        .st_fva   (fst_fva),
        .locked   (fst_locked)
    );

    dxl_counters #(.CNT_W(CNT_W)) i_counters (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (req_valid),
        .ev_write (req_write),
        .ev_kind  (c_kind),
        .cnt      (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= c_fault;
            rsp_paddr <= c_paddr;
        end
    end

    assign rd_hits    = cnt[0];
    assign rd_misses  = cnt[1];
    assign rd_viol    = cnt[2];
    assign wr_hits    = cnt[NUM_KIND + 0];
    assign wr_misses  = cnt[NUM_KIND + 1];
    assign wr_viol    = cnt[NUM_KIND + 2];
    assign rd_acc     = rd_hits + rd_misses + rd_viol;
    assign wr_acc     = wr_hits + wr_misses + wr_viol;
    assign all_hits   = rd_hits + wr_hits;
    assign all_misses = rd_misses + wr_misses;
    assign all_viol   = rd_viol + wr_viol;
    assign all_acc    = rd_acc + wr_acc;

endmodule

// File: rtl/dxl_checker.sv
module dxl_checker #(
    parameter int VA_W  = 43,
    parameter int FVA_W = 64,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             va_rd,
    input logic             rsp_valid,
    input logic [2:0]       rsp_fault,
    input logic [VA_W-1:0]  fst_va,
    input logic [16:0]      fst_word,
    input logic [FVA_W-1:0] fst_fva,
    input logic             fst_locked,
    input logic [CNT_W-1:0] all_acc
);

    p_lock_set_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fst_locked) |-> (rsp_valid && rsp_fault != 3'd0));

    p_unlock_r9: assert property (@(posedge clk) disable iff (rst)
        (va_rd && fst_locked) |=> !fst_locked);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (fst_locked && !va_rd) |=> (fst_locked && $stable(fst_va)
                                    && $stable(fst_word) && $stable(fst_fva)));

    p_acc_step_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (all_acc == CNT_W'($past(all_acc) + 1'b1)));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(all_acc) && !rsp_valid));

    p_miss_flag_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(fst_locked) && (rsp_fault == 3'd3 || rsp_fault == 3'd4)) |-> fst_word[5]);

endmodule

bind dxlate_unit dxl_checker #(.VA_W(VA_W), .FVA_W(FVA_W), .CNT_W(CNT_W)) i_dxl_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .va_rd      (va_rd),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .fst_va     (fst_va),
    .fst_word   (fst_word),
    .fst_fva    (fst_fva),
    .fst_locked (fst_locked),
    .all_acc    (all_acc)
);

// File: tb/test_dxlate_unit.sv
module test_dxlate_unit;

    localparam int NV = 19;
    localparam logic [42:0] VN  = 43'h012_3456_789A;
    localparam logic [42:0] VS  = 43'h402_4681_3579;
    localparam logic [42:0] VA1 = 43'h123_4567_89AB;
    localparam logic [42:0] VA2 = 43'h055_5555_5000;
    localparam logic [27:0] PFN = 28'h1234567;
    localparam logic [63:0] PTB = 64'hFFF0_0000_0000_0000;

    typedef struct packed {
        logic wr; logic alt; logic ptf;
        logic [1:0] cm; logic [1:0] am; logic pal;
        logic sp; logic vok; logic hit;
        logic [3:0] ren; logic [3:0] wen;
        logic frt; logic fwt;
        logic [42:0] va;
        logic [2:0] ef; logic [5:0] efl;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h8,4'h0,1'b0,1'b0,VN,3'd0,6'd0},  // R7 load hit
        '{1'b1,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h0,4'h8,1'b0,1'b0,VN,3'd0,6'd0},  // R7 store hit
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h1,4'h0,1'b1,1'b0,VN,3'd1,6'd6},  // R6 no read enable
        '{1'b1,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h0,4'h1,1'b0,1'b1,VN,3'd2,6'd11}, // R5 no write enable
        '{1'b1,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h0,4'h8,1'b0,1'b1,VN,3'd2,6'd9},  // R5 write trap
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h8,4'h0,1'b1,1'b0,VN,3'd2,6'd4},  // R6 read trap
        '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,4'hF,4'hF,1'b0,1'b0,VN,3'd2,6'd18}, // R2 bad load
        '{1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,4'hF,4'hF,1'b0,1'b0,VN,3'd2,6'd19}, // R2 bad store
        '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,4'hF,4'hF,1'b0,1'b0,VN,3'd3,6'd32}, // R4 miss
        '{1'b1,1'b0,1'b1,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,4'hF,4'hF,1'b0,1'b0,VN,3'd4,6'd33}, // R4 pte miss
        '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,VS,3'd0,6'd0},  // R3 kernel window
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,1'b1,1'b1,1'b1,4'hF,4'hF,1'b0,1'b0,VS,3'd1,6'd2},  // R3 user window
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b0,4'hF,4'hF,1'b0,1'b0,VS,3'd3,6'd32}, // R3 window off
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b1,1'b0,1'b1,1'b1,4'h1,4'h0,1'b0,1'b0,VN,3'd0,6'd0},  // R1 priv kernel
        '{1'b0,1'b1,1'b0,2'd3,2'd2,1'b1,1'b0,1'b1,1'b1,4'h4,4'h0,1'b0,1'b0,VN,3'd0,6'd0},  // R1 alt supervisor
        '{1'b0,1'b1,1'b0,2'd0,2'd3,1'b1,1'b0,1'b1,1'b1,4'h1,4'h0,1'b0,1'b0,VN,3'd1,6'd2},  // R1 alt user
        '{1'b0,1'b1,1'b0,2'd3,2'd0,1'b0,1'b0,1'b1,1'b1,4'h1,4'h0,1'b0,1'b0,VN,3'd1,6'd2},  // R1 alt ignored
        '{1'b1,1'b0,1'b0,2'd3,2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,4'hF,1'b0,1'b0,VS,3'd1,6'd3},  // R3 current mode
        '{1'b0,1'b0,1'b0,2'd3,2'd0,1'b0,1'b1,1'b0,1'b1,4'hF,4'hF,1'b0,1'b0,VS,3'd2,6'd18}  // R2 order
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [42:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_altmode = 1'b0, req_ptefetch = 1'b0;
    logic [5:0]  req_opcode = '0;
    logic [4:0]  req_rdst = '0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic        priv_pc = 1'b0, spage_on = 1'b0, va_ok = 1'b1, tlb_hit = 1'b0;
    logic [27:0] tlb_pfn = PFN;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_rd_trap = 1'b0, tlb_wr_trap = 1'b0;
    logic [63:0] pt_base = PTB;
    logic        va_rd = 1'b0;
    logic        rsp_valid, fst_locked;
    logic [2:0]  rsp_fault;
    logic [40:0] rsp_paddr;
    logic [42:0] fst_va;
    logic [16:0] fst_word;
    logic [63:0] fst_fva;
    logic [15:0] rd_hits, rd_misses, rd_viol, rd_acc;
    logic [15:0] wr_hits, wr_misses, wr_viol, wr_acc;
    logic [15:0] all_hits, all_misses, all_viol, all_acc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dxlate_unit i_dxlate_unit (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            0, 1:            return "R7";
            2, 5:            return "R6";
            3, 4:            return "R5";
            6, 7, 18:        return "R2";
            8, 9:            return "R4";
            10, 11, 12, 17:  return "R3";
            default:         return "R1";
        endcase
    endfunction

    task automatic apply(input vec_t v, input logic [5:0] opc, input logic [4:0] rd, input logic rdstrobe);
        req_valid = 1'b1; req_vaddr = v.va; req_write = v.wr; req_altmode = v.alt;
        req_ptefetch = v.ptf; cur_mode = v.cm; alt_mode = v.am; priv_pc = v.pal;
        spage_on = v.sp; va_ok = v.vok; tlb_hit = v.hit; tlb_rd_en = v.ren;
        tlb_wr_en = v.wen; tlb_rd_trap = v.frt; tlb_wr_trap = v.fwt;
        req_opcode = opc; req_rdst = rd; va_rd = rdstrobe;
        @(negedge clk);
        req_valid = 1'b0; va_rd = 1'b0;
    endtask

    task automatic read_va();
        va_rd = 1'b1;
        @(negedge clk);
        va_rd = 1'b0;
    endtask

    // directed fault vectors
    function automatic vec_t miss_vec(input logic [42:0] va);
        return '{1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,4'hF,4'hF,1'b0,1'b0,va,3'd3,6'd32};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t_rh = 0, t_rm = 0, t_rv = 0, t_wh = 0, t_wm = 0, t_wv = 0;
        vec_t d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 fst_locked", 64'(fst_locked), 64'd0);
        check("R11 fst_va", 64'(fst_va), 64'd0);
        check("R11 fst_word", 64'(fst_word), 64'd0);
        check("R11 fst_fva", fst_fva, 64'd0);
        check("R11 all_acc", 64'(all_acc), 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [40:0] exp_pa;
            apply(VECS[i], 6'(i + 3), 5'(i + 1), 1'b0);
            check({vtag(i), " valid"}, 64'(rsp_valid), 64'd1);
            check({vtag(i), " fault"}, 64'(rsp_fault), 64'(VECS[i].ef));
            if (VECS[i].ef == 3'd0) begin
                exp_pa = (VECS[i].sp && VECS[i].va[42:41] == 2'd2) ? VECS[i].va[40:0]
                                                                   : {PFN, VECS[i].va[12:0]};
                check({vtag(i), " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
                check("R9 no lock on hit", 64'(fst_locked), 64'd0);
            end else begin
                check({vtag(i), " R8 word"}, 64'(fst_word), 64'({6'(i + 3), 5'(i + 1), VECS[i].efl}));
                check("R8 fst_va", 64'(fst_va), 64'(VECS[i].va));
                check("R9 locked", 64'(fst_locked), 64'd1);
                read_va();
                check("R9 unlock", 64'(fst_locked), 64'd0);
            end
            case (VECS[i].ef)
                3'd0:       if (VECS[i].wr) t_wh++; else t_rh++;
                3'd3, 3'd4: if (VECS[i].wr) t_wm++; else t_rm++;
                default:    if (VECS[i].wr) t_wv++; else t_rv++;
            endcase
        end

        // R10 counters
        check("R10 rd_hits", 64'(rd_hits), 64'(t_rh));
        check("R10 rd_misses", 64'(rd_misses), 64'(t_rm));
        check("R10 rd_viol", 64'(rd_viol), 64'(t_rv));
        check("R10 rd_acc", 64'(rd_acc), 64'(t_rh + t_rm + t_rv));
        check("R10 wr_hits", 64'(wr_hits), 64'(t_wh));
        check("R10 wr_misses", 64'(wr_misses), 64'(t_wm));
        check("R10 wr_viol", 64'(wr_viol), 64'(t_wv));
        check("R10 wr_acc", 64'(wr_acc), 64'(t_wh + t_wm + t_wv));
        check("R10 all_hits", 64'(all_hits), 64'(t_rh + t_wh));
        check("R10 all_misses", 64'(all_misses), 64'(t_rm + t_wm));
        check("R10 all_viol", 64'(all_viol), 64'(t_rv + t_wv));
        check("R10 all_acc", 64'(all_acc), 64'(NV));
        repeat (3) @(negedge clk);
        check("R10 idle acc", 64'(all_acc), 64'(NV));
        check("R10 idle valid", 64'(rsp_valid), 64'd0);

        // R8 full record on a miss
        apply(miss_vec(VA1), 6'h2A, 5'h15, 1'b0);
        check("R8 word", 64'(fst_word), 64'({6'h2A, 5'h15, 6'h20}));
        check("R8 fva", fst_fva, PTB | (64'(VA1[42:13]) << 3));
        check("R8 va", 64'(fst_va), 64'(VA1));
        check("R9 locked", 64'(fst_locked), 64'd1);

        // R9 second fault does not overwrite
        d = VECS[7]; d.va = VA2;
        apply(d, 6'h01, 5'h02, 1'b0);
        check("R9 second fault code", 64'(rsp_fault), 64'd2);
        check("R9 va kept", 64'(fst_va), 64'(VA1));
        check("R9 word kept", 64'(fst_word), 64'({6'h2A, 5'h15, 6'h20}));
        read_va();
        check("R9 read unlocks", 64'(fst_locked), 64'd0);
        check("R9 read keeps va", 64'(fst_va), 64'(VA1));

        // R9 fresh fault after read is recorded
        d = VECS[16]; d.va = VA2;
        apply(d, 6'h11, 5'h03, 1'b0);
        check("R9 new va", 64'(fst_va), 64'(VA2));
        check("R9 new word", 64'(fst_word), 64'({6'h11, 5'h03, 6'h02}));

        // R9 fault together with read while locked: dropped, lock clears
        apply(miss_vec(VA1), 6'h3F, 5'h1F, 1'b1);
        check("R9 same-cycle va", 64'(fst_va), 64'(VA2));
        check("R9 same-cycle unlock", 64'(fst_locked), 64'd0);
        apply(miss_vec(VA1), 6'h05, 5'h06, 1'b0);
        check("R9 reload va", 64'(fst_va), 64'(VA1));
        check("R9 relock", 64'(fst_locked), 64'd1);
        check("R4 miss flag", 64'(fst_word[5]), 64'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule